// File: doc/BRIEF.md
# Rotary Knob Decimal Frequency Editor

This block turns a quadrature rotary knob with an integrated push switch into an editor for a nine-digit decimal frequency setting. The setting spans units of hertz up to the hundreds-of-megahertz digit. Downstream logic reads it as a packed BCD vector and can recompute its tuning values whenever the change strobe fires.

Two editing modes alternate with each full press and release of the knob. In cursor mode, rotation moves a cursor across the digit positions. In value mode, rotation steps the digit under that cursor up or down. The block also drives a cursor index for a display to draw a marker, a per-digit blanking mask for the two top digits, and a pair of mode indicator lines.

All three knob inputs are asynchronous. Each passes through a two-flop synchroniser and a stability filter before any decoding.

Top module: `freq_editor`

## Requirements
- R1: After reset the digits hold 000000001 (1 Hz), the cursor is 0, cursor mode is active and `valueChanged` is low.
- R2: Each knob input is first synchronised. A change on it takes effect only after the synchronised level has differed from the filtered level for DEB_CYCLES consecutive clocks. A pulse shorter than that has no effect.
- R3: The mode toggles on the release (falling edge) of the filtered push input only. Pressing and holding does not change the mode.
- R4: `ledCursorMode` is high in cursor mode and `ledValueMode` is high in value mode. Exactly one of them is high at any time.
- R5: One step is decoded per detent, on the rising edge of the filtered A input. B low at that edge means clockwise and B high means anticlockwise. Edges on B alone produce no step.
- R6: In cursor mode a clockwise step moves the cursor one position toward the more significant digits and an anticlockwise step moves it one position toward the units. The cursor saturates at 0 and at NUM_DIGITS-1 (8, the 100 MHz digit), and the digits do not change.
- R7: In value mode a clockwise step increments the digit under the cursor and an anticlockwise step decrements it. The digit wraps 9 to 0 and 0 to 9 with no carry or borrow into other digits, and the cursor does not move.
- R8: Digit i occupies bits [4i+3:4i] of `digits`. Digit 0 is units and digit 8 is the 100 MHz digit. Every digit is a BCD value of 0 to 9.
- R9: `blank[i]` is high exactly when i is at least BLANK_FROM (7, so the 10 MHz and 100 MHz digits) and digit i is zero. All lower bits are low.
- R10: `valueChanged` is high for exactly one clock, in the cycle the new digit value first appears, for every digit change. It is low otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| knobA | input | 1 | Quadrature phase A from the knob, asynchronous |
| knobB | input | 1 | Quadrature phase B from the knob, asynchronous |
| knobPress | input | 1 | Knob push switch, high while pressed, asynchronous |
| digits | output | 4*NUM_DIGITS (36) | Packed BCD frequency digits, units in the low nibble |
| cursor | output | $clog2(NUM_DIGITS) (4) | Index of the selected digit |
| blank | output | NUM_DIGITS (9) | Per-digit blanking flags |
| ledCursorMode | output | 1 | High in cursor mode |
| ledValueMode | output | 1 | High in value mode |
| valueChanged | output | 1 | One-clock strobe on any digit change |

## Verification
Several invariants are checked on every cycle:
- exactly one mode line is high;
- every digit is BCD and the cursor stays in range;
- the cursor moves by one position and only out of cursor mode;
- digits change only out of value mode, and at most one digit changes at a time;
- the change strobe coincides with a digit change.

Other behaviour can only be shown by the scenarios. These cover the detent direction decode and the rejection of short glitches on the knob and switch. They also cover release-only toggling, saturation at both cursor ends, 9/0 wrapping without carry, and the blanking flags following the top digits.

// File: rtl/fe_pkg.sv
package fe_pkg;

  // Edit requests from the control to the datapath, each one clock long.
  typedef struct packed {
    logic curInc;   // cursor toward more significant digits
    logic curDec;   // cursor toward units
    logic digInc;   // selected digit up
    logic digDec;   // selected digit down
  } edit_strobe_t;

endpackage

// File: rtl/fe_cond.sv
module fe_cond #(
  parameter int WIDTH      = 3,
  parameter int DEB_CYCLES = 64
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] rawIn,
  output logic [WIDTH-1:0] cleanOut
);

  localparam int CNT_W = $clog2(DEB_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DEB_CYCLES - 1);

  for (genvar gi = 0; gi < WIDTH; gi++) begin : g_bit
    logic [1:0]       syncQ;
    logic [CNT_W-1:0] cntQ;
    logic             stableQ;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        syncQ   <= '0;
        cntQ    <= '0;
        stableQ <= 1'b0;
      end else begin
        syncQ <= {syncQ[0], rawIn[gi]};
        if (syncQ[1] == stableQ) begin
          cntQ <= '0;
        end else if (cntQ == CNT_LAST) begin
          stableQ <= syncQ[1];
          cntQ    <= '0;
        end else begin
          cntQ <= cntQ + 1'b1;
        end
      end
    end

    assign cleanOut[gi] = stableQ;
  end

endmodule

// File: rtl/fe_ctrl.sv
module fe_ctrl
  import fe_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         cleanA,
  input  logic         cleanB,
  input  logic         cleanPress,
  output edit_strobe_t strobe,
  output logic         valueMode
);

  logic prevA;
  logic prevPress;
  logic valueModeQ;
  logic aRise;
  logic pressRelease;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevA      <= 1'b0;
      prevPress  <= 1'b0;
      valueModeQ <= 1'b0;
    end else begin
      prevA     <= cleanA;
      prevPress <= cleanPress;
      if (pressRelease) valueModeQ <= ~valueModeQ;
    end
  end

  assign aRise        = cleanA & ~prevA;
  assign pressRelease = prevPress & ~cleanPress;

  // B low at the A rising edge means clockwise.
  always_comb begin
    strobe        = '0;
    strobe.curInc = aRise & ~cleanB & ~valueModeQ;
    strobe.curDec = aRise &  cleanB & ~valueModeQ;
    strobe.digInc = aRise & ~cleanB &  valueModeQ;
    strobe.digDec = aRise &  cleanB &  valueModeQ;
  end

  assign valueMode = valueModeQ;

endmodule

// File: rtl/fe_dpath.sv
module fe_dpath
  import fe_pkg::*;
#(
  parameter int NUM_DIGITS = 9,
  parameter int BLANK_FROM = 7
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  edit_strobe_t                  strobe,
  output logic [4*NUM_DIGITS-1:0]       digits,
  output logic [$clog2(NUM_DIGITS)-1:0] cursor,
  output logic [NUM_DIGITS-1:0]         blank,
  output logic                          valueChanged
);

  localparam int CUR_W = $clog2(NUM_DIGITS);
  localparam logic [CUR_W-1:0] CUR_LAST = CUR_W'(NUM_DIGITS - 1);

  logic [CUR_W-1:0] cursorQ;
  logic             changedQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cursorQ  <= '0;
      changedQ <= 1'b0;
    end else begin
      changedQ <= strobe.digInc | strobe.digDec;
      if (strobe.curInc && cursorQ != CUR_LAST)
        cursorQ <= cursorQ + 1'b1;
      else if (strobe.curDec && cursorQ != '0)
        cursorQ <= cursorQ - 1'b1;
    end
  end

  for (genvar gi = 0; gi < NUM_DIGITS; gi++) begin : g_digit
    localparam logic [3:0] RST_VAL = (gi == 0) ? 4'd1 : 4'd0;
    logic [3:0] digQ;
    logic       sel;

    assign sel = (cursorQ == CUR_W'(gi));

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        digQ <= RST_VAL;
      end else if (sel && strobe.digInc) begin
        digQ <= (digQ == 4'd9) ? 4'd0 : digQ + 4'd1;
      end else if (sel && strobe.digDec) begin
        digQ <= (digQ == 4'd0) ? 4'd9 : digQ - 4'd1;
      end
    end

    assign digits[4*gi +: 4] = digQ;

    if (gi >= BLANK_FROM) begin : g_blank
      assign blank[gi] = (digQ == 4'd0);
    end else begin : g_show
      assign blank[gi] = 1'b0;
    end
  end

  assign cursor       = cursorQ;
  assign valueChanged = changedQ;

endmodule

// File: rtl/freq_editor.sv
module freq_editor
  import fe_pkg::*;
#(
  parameter int NUM_DIGITS = 9,
  parameter int BLANK_FROM = 7,
  parameter int DEB_CYCLES = 64
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          knobA,
  input  logic                          knobB,
  input  logic                          knobPress,
  output logic [4*NUM_DIGITS-1:0]       digits,
  output logic [$clog2(NUM_DIGITS)-1:0] cursor,
  output logic [NUM_DIGITS-1:0]         blank,
  output logic                          ledCursorMode,
  output logic                          ledValueMode,
  output logic                          valueChanged
);

  logic [2:0]   clean;
  edit_strobe_t strobe;
  logic         valueMode;

  fe_cond #(
    .WIDTH     (3),
    .DEB_CYCLES(DEB_CYCLES)
  ) u_cond (
    .clk     (clk),
    .rstN    (rstN),
    .rawIn   ({knobPress, knobB, knobA}),
    .cleanOut(clean)
  );

  fe_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .cleanA    (clean[0]),
    .cleanB    (clean[1]),
    .cleanPress(clean[2]),
    .strobe    (strobe),
    .valueMode (valueMode)
  );

  fe_dpath #(
    .NUM_DIGITS(NUM_DIGITS),
    .BLANK_FROM(BLANK_FROM)
  ) u_dpath (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .digits      (digits),
    .cursor      (cursor),
    .blank       (blank),
    .valueChanged(valueChanged)
  );

  assign ledCursorMode = ~valueMode;
  assign ledValueMode  = valueMode;

endmodule

// File: rtl/fe_checker.sv
module fe_checker #(
  parameter int NUM_DIGITS = 9
) (
  input logic                          clk,
  input logic                          rstN,
  input logic [4*NUM_DIGITS-1:0]       digits,
  input logic [$clog2(NUM_DIGITS)-1:0] cursor,
  input logic                          ledCursorMode,
  input logic                          ledValueMode,
  input logic                          valueChanged
);

  localparam int CUR_W = $clog2(NUM_DIGITS);

  logic [4*NUM_DIGITS-1:0] prevDigits;
  logic                    bcdOk;
  int                      diffCnt;

  always_ff @(posedge clk) prevDigits <= digits;

  always_comb begin
    bcdOk   = 1'b1;
    diffCnt = 0;
    for (int i = 0; i < NUM_DIGITS; i++) begin
      if (digits[4*i +: 4] > 4'd9) bcdOk = 1'b0;
      if (digits[4*i +: 4] != prevDigits[4*i +: 4]) diffCnt++;
    end
  end

  p_mode_onehot_r4: assert property (@(posedge clk) disable iff (!rstN)
    $countones({ledCursorMode, ledValueMode}) == 1);

  p_digit_bcd_r8: assert property (@(posedge clk) disable iff (!rstN)
    bcdOk);

  p_cursor_range_r6: assert property (@(posedge clk) disable iff (!rstN)
    cursor <= CUR_W'(NUM_DIGITS - 1));

  p_cursor_step_r6: assert property (@(posedge clk) disable iff (!rstN)
    (cursor != $past(cursor)) |->
      ($past(ledCursorMode) &&
       ((cursor == $past(cursor) + 1'b1) || ($past(cursor) == cursor + 1'b1))));

  p_digits_frozen_r6: assert property (@(posedge clk) disable iff (!rstN)
    ledCursorMode |=> $stable(digits));

  p_cursor_frozen_r7: assert property (@(posedge clk) disable iff (!rstN)
    ledValueMode |=> $stable(cursor));

  p_one_digit_r7: assert property (@(posedge clk) disable iff (!rstN)
    valueChanged |-> (diffCnt == 1));

  p_change_strobe_r10: assert property (@(posedge clk) disable iff (!rstN)
    (digits != $past(digits)) |-> valueChanged);

  p_strobe_pulse_r10: assert property (@(posedge clk) disable iff (!rstN)
    valueChanged |=> !valueChanged);

endmodule

bind freq_editor fe_checker #(.NUM_DIGITS(NUM_DIGITS)) u_fe_checker (
  .clk          (clk),
  .rstN         (rstN),
  .digits       (digits),
  .cursor       (cursor),
  .ledCursorMode(ledCursorMode),
  .ledValueMode (ledValueMode),
  .valueChanged (valueChanged)
);

// File: tb/test_freq_editor.sv
module test_freq_editor;

  localparam int CLK_PERIOD = 10;
  localparam int DEB        = 64;
  localparam int SETTLE     = DEB + 8;
  localparam int NROWS      = 19;

  // {op[1:0], reps[4:0], expValueMode, expCursor[3:0], expDigits[35:0]}
  // op: 0 clockwise detents, 1 anticlockwise detents, 2 press and release
  localparam logic [47:0] OPS [NROWS] = '{
    {2'd2, 5'd1,  1'b1, 4'd0, 36'h000000001},
    {2'd0, 5'd3,  1'b1, 4'd0, 36'h000000004},
    {2'd1, 5'd6,  1'b1, 4'd0, 36'h000000008},
    {2'd2, 5'd1,  1'b0, 4'd0, 36'h000000008},
    {2'd0, 5'd2,  1'b0, 4'd2, 36'h000000008},
    {2'd2, 5'd1,  1'b1, 4'd2, 36'h000000008},
    {2'd0, 5'd12, 1'b1, 4'd2, 36'h000000208},
    {2'd2, 5'd1,  1'b0, 4'd2, 36'h000000208},
    {2'd0, 5'd9,  1'b0, 4'd8, 36'h000000208},
    {2'd2, 5'd1,  1'b1, 4'd8, 36'h000000208},
    {2'd1, 5'd1,  1'b1, 4'd8, 36'h900000208},
    {2'd2, 5'd1,  1'b0, 4'd8, 36'h900000208},
    {2'd1, 5'd1,  1'b0, 4'd7, 36'h900000208},
    {2'd2, 5'd1,  1'b1, 4'd7, 36'h900000208},
    {2'd0, 5'd10, 1'b1, 4'd7, 36'h900000208},
    {2'd2, 5'd1,  1'b0, 4'd7, 36'h900000208},
    {2'd1, 5'd15, 1'b0, 4'd0, 36'h900000208},
    {2'd2, 5'd1,  1'b1, 4'd0, 36'h900000208},
    {2'd1, 5'd1,  1'b1, 4'd0, 36'h900000207}
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        knobA = 1'b0;
  logic        knobB = 1'b0;
  logic        knobPress = 1'b0;
  logic [35:0] digits;
  logic [3:0]  cursor;
  logic [8:0]  blank;
  logic        ledCursorMode;
  logic        ledValueMode;
  logic        valueChanged;

  int checks = 0;
  int errors = 0;
  int pulseCnt = 0;
  bit done = 1'b0;

  freq_editor i_freq_editor (
    .clk          (clk),
    .rstN         (rstN),
    .knobA        (knobA),
    .knobB        (knobB),
    .knobPress    (knobPress),
    .digits       (digits),
    .cursor       (cursor),
    .blank        (blank),
    .ledCursorMode(ledCursorMode),
    .ledValueMode (ledValueMode),
    .valueChanged (valueChanged)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  always @(negedge clk) if (rstN && valueChanged) pulseCnt++;

  task automatic check(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic settle();
    repeat (SETTLE) @(negedge clk);
  endtask

  task automatic detent(input bit cw);
    if (cw) begin
      knobA = 1'b1; settle(); knobB = 1'b1; settle();
      knobA = 1'b0; settle(); knobB = 1'b0; settle();
    end else begin
      knobB = 1'b1; settle(); knobA = 1'b1; settle();
      knobB = 1'b0; settle(); knobA = 1'b0; settle();
    end
  endtask

  task automatic pressRelease();
    knobPress = 1'b1; settle();
    knobPress = 1'b0; settle();
  endtask

  function automatic logic [8:0] expBlank(input logic [35:0] d);
    logic [8:0] b;
    for (int i = 0; i < 9; i++) b[i] = (i >= 7) && (d[4*i +: 4] == 4'd0);
    return b;
  endfunction

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  task automatic checkReset();
    check("R1", "digits after reset", 64'(digits), 64'h1);
    check("R1", "cursor after reset", 64'(cursor), 64'h0);
    check("R1", "changed after reset", 64'(valueChanged), 64'h0);
    check("R4", "mode lines after reset", 64'({ledValueMode, ledCursorMode}), 64'h1);
    check("R9", "blank after reset", 64'(blank), 64'h180);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    bit valueModeNow = 1'b0;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    checkReset();

    // Table walk: R3, R5, R6, R7, R8, R9, R10
    for (int r = 0; r < NROWS; r++) begin
      logic [47:0] row;
      int expPulses;
      row = OPS[r];
      expPulses = (row[47:46] != 2'd2 && valueModeNow) ? int'(row[45:41]) : 0;
      pulseCnt = 0;
      if (row[47:46] == 2'd2) pressRelease();
      else for (int k = 0; k < int'(row[45:41]); k++) detent(row[47:46] == 2'd0);
      valueModeNow = row[40];
      check("R3", $sformatf("row %0d value mode line", r), 64'(ledValueMode), 64'(row[40]));
      check("R4", $sformatf("row %0d cursor mode line", r), 64'(ledCursorMode), 64'(!row[40]));
      check("R6", $sformatf("row %0d cursor", r), 64'(cursor), 64'(row[39:36]));
      check("R7", $sformatf("row %0d digits", r), 64'(digits), 64'(row[35:0]));
      check("R9", $sformatf("row %0d blank", r), 64'(blank), 64'(expBlank(row[35:0])));
      check("R10", $sformatf("row %0d change pulses", r), 64'(pulseCnt), 64'(expPulses));
    end

    // R9: 10 MHz digit nonzero clears its blank flag (value mode, cursor 0 now)
    pressRelease();
    for (int k = 0; k < 7; k++) detent(1'b1);
    pressRelease();
    detent(1'b0);
    check("R9", "blank with top digits nonzero", 64'(blank), 64'h000);
    check("R8", "digit 7 at bits 31:28", 64'(digits[31:28]), 64'h9);
    check("R7", "wrap without borrow", 64'(digits), 64'h990000207);
    // Now value mode, cursor 7.

    // R2: short glitch on A is ignored
    pulseCnt = 0;
    knobA = 1'b1; repeat (DEB / 2) @(negedge clk); knobA = 1'b0; settle();
    check("R2", "digits after A glitch", 64'(digits), 64'h990000207);
    check("R2", "pulses after A glitch", 64'(pulseCnt), 64'h0);

    // R2: short glitch on the switch is ignored
    knobPress = 1'b1; repeat (DEB / 2) @(negedge clk); knobPress = 1'b0; settle();
    check("R2", "mode after press glitch", 64'(ledValueMode), 64'h1);

    // R5: B toggling alone gives no step
    knobB = 1'b1; settle(); knobB = 1'b0; settle();
    check("R5", "digits after B-only edges", 64'(digits), 64'h990000207);
    check("R5", "pulses after B-only edges", 64'(pulseCnt), 64'h0);

    // R3: holding the switch does not toggle; releasing does
    knobPress = 1'b1; settle(); settle();
    check("R3", "mode while held", 64'(ledValueMode), 64'h1);
    knobPress = 1'b0; settle();
    check("R3", "mode after release", 64'(ledValueMode), 64'h0);

    // R1: reset in mid-run
    @(negedge clk); rstN = 1'b0;
    repeat (3) @(negedge clk); rstN = 1'b1;
    repeat (2) @(negedge clk);
    checkReset();

    done = 1'b1;
    summary();
    $finish;
  end

endmodule